// File: doc/BRIEF.md
# Retirement-Based Watchpoint Event Reporter

This block sits between the debug comparators and the retirement stage of a processor that can retire up to two instructions per clock. Both comparator paths deliver hits tagged with the owning instruction's tag. The fetch path sends instruction watchpoints and instruction breakpoints. The load/store path sends data watchpoints and data breakpoints, together with the access address. The block gathers these hits in a small table with one entry per tag. A hit that repeats on the same instruction, for example once per transfer of a multi-word access, is merged into a single flag.

Nothing is reported while an instruction is in flight. Its merged flags turn into outputs only when the instruction retires. At that point the block produces a one-cycle event pulse per watchpoint kind and per retire slot, and it advances two wrapping event counters. It can also raise one breakpoint request. An instruction breakpoint is flagged as taken before execution. A data breakpoint is flagged as taken after execution, and the address of the first breakpointing access of that instruction is loaded into the breakpoint address register. Flushed instructions have their entries cleared, so their hits never appear.

The block has no handshake toward the pipeline and never holds retirement back.

Top module: `wp_retire_reporter`

## Requirements
- R1: Any number of hits of one kind on one instruction, including repeats across cycles, produce at most one event for that instruction, and advance that kind's counter by at most one.
- R2: `iwp_count` and `lsw_count` reset to 0. Each one increases by the number of bits set in the event vector of its own kind, which is 0, 1 or 2 per cycle, and wraps modulo 2^CNT_W.
- R3: When slot s of `ret_v` retires tag T in cycle N, bit s of `iwp_evt` and bit s of `lsw_evt` are high in cycle N+1 exactly when T had a pending hit of that kind. Slot 0 is the older instruction. The event outputs are low in every other case.
- R4: A bit set in `flush_mask` clears that tag's pending hits. A hit arriving in the same cycle as a flush or a retirement of its own tag is dropped. A later retirement of a cleared tag reports nothing.
- R5: When a retiring instruction holds an instruction breakpoint, `bp_req` is high in the next cycle with `bp_after` = 0, and `bar` keeps its value.
- R6: When a retiring instruction holds only a data breakpoint, `bp_req` is high in the next cycle with `bp_after` = 1. In that same cycle `bar` takes the address of the instruction's first data-breakpoint hit. `bar` changes at no other time. `bp_after` is 0 whenever `bp_req` is 0.
- R7: Further data-breakpoint hits on an instruction that already holds one leave its captured address unchanged. No request is raised before the instruction retires.
- R8: With `bp_masked_mode` = 1 and `bp_enable` = 0, no breakpoint request is raised, while watchpoint events still are. With `bp_masked_mode` = 0, `bp_enable` has no effect.
- R9: When the older retiring instruction takes a breakpoint, the younger one in the same cycle reports no events, adds nothing to the counts and has its entry cleared. `bp_tag` gives the taking instruction's tag, and it is 0 when there is no request.
- R10: An instruction holding both an instruction and a data breakpoint is reported with `bp_after` = 0.
- R11: After reset, all outputs are 0.
- R12: Retiring an instruction that has no pending hits produces no event, no count and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_hit_v | input | 1 | Fetch-side hit valid |
| if_hit_tag | input | TAG_W | Tag of the instruction hit on the fetch side |
| if_hit_wp | input | 1 | Instruction watchpoint hit |
| if_hit_bp | input | 1 | Instruction breakpoint hit |
| ls_hit_v | input | 1 | Load/store-side hit valid |
| ls_hit_tag | input | TAG_W | Tag of the instruction hit on the load/store side |
| ls_hit_wp | input | 1 | Data watchpoint hit |
| ls_hit_bp | input | 1 | Data breakpoint hit |
| ls_hit_addr | input | ADDR_W | Access address of the load/store hit |
| flush_mask | input | 2^TAG_W | One bit per tag to discard |
| ret_v | input | RET_N | Retire valid per slot, slot 0 oldest |
| ret_tag | input | RET_N*TAG_W | Retiring tags, slot s at bits s*TAG_W upward |
| bp_masked_mode | input | 1 | Breakpoints obey `bp_enable` when set |
| bp_enable | input | 1 | Breakpoint enable mask bit |
| iwp_evt | output | RET_N | Instruction watchpoint event per slot |
| lsw_evt | output | RET_N | Data watchpoint event per slot |
| iwp_count | output | CNT_W | Instruction watchpoint event counter |
| lsw_count | output | CNT_W | Data watchpoint event counter |
| bp_req | output | 1 | Breakpoint exception request pulse |
| bp_after | output | 1 | 1 when taken after execution, 0 when taken before |
| bp_tag | output | TAG_W | Tag of the instruction taking the breakpoint |
| bar | output | ADDR_W | Breakpoint address register |

## Verification
Two retirements can land in the same clock. When both of them carry breakpoints, older-first priority and the cancellation of the younger slot decide the outcome together. The bench sets this up by loading a data breakpoint on the slot-0 tag and an instruction breakpoint plus a watchpoint on the slot-1 tag, then retiring both at once. It expects a single after-execution request on the older tag, no events or counts from slot 1, and nothing when the younger tag is retired again later. Hit arrival in the same cycle as a flush or retirement of that tag is a second collision. It is provoked directly, and also throughout a long pseudo-random phase, with an arithmetic model of the table judging every cycle.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    // Merged hit flags held per in-flight instruction
    typedef struct packed {
        logic ifetch_wp;
        logic ifetch_bp;
        logic mem_wp;
        logic mem_bp;
    } wpr_flags_t;

    // Point at which a breakpoint exception is taken
    typedef enum logic {
        BP_BEFORE = 1'b0,
        BP_AFTER  = 1'b1
    } wpr_when_e;

    // Number of watchpoint kinds that own a counter
    localparam int unsigned WPR_NWT = 2;

    function automatic logic bp_allowed(input logic masked_mode, input logic enable);
        return !masked_mode || enable;
    endfunction

    function automatic logic has_bp(input wpr_flags_t f);
        return f.ifetch_bp || f.mem_bp;
    endfunction

endpackage

// File: rtl/wpr_hit_table.sv
module wpr_hit_table
    import wpr_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 16,
    parameter int RET_N  = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               if_v,
    input  logic [TAG_W-1:0]                   if_tag,
    input  logic                               if_wp,
    input  logic                               if_bp,
    input  logic                               ls_v,
    input  logic [TAG_W-1:0]                   ls_tag,
    input  logic                               ls_wp,
    input  logic                               ls_bp,
    input  logic [ADDR_W-1:0]                  ls_addr,
    input  logic [(1<<TAG_W)-1:0]              kill_mask,
    input  logic [RET_N-1:0][TAG_W-1:0]        rd_tag,
    output wpr_flags_t [RET_N-1:0]             rd_flags,
    output logic [RET_N-1:0][ADDR_W-1:0]       rd_addr
);
    localparam int DEPTH = 1 << TAG_W;

    wpr_flags_t [DEPTH-1:0]             flags_q, flags_d;
    logic       [DEPTH-1:0][ADDR_W-1:0] addr_q,  addr_d;

    // Merge new hits into the entry; a kill of the same tag wins over a hit
    always_comb begin
        flags_d = flags_q;
        addr_d  = addr_q;
        for (int e = 0; e < DEPTH; e++) begin
            if (kill_mask[e]) begin
                flags_d[e] = '0;
            end else begin
                if (if_v && (if_tag == TAG_W'(e))) begin
                    flags_d[e].ifetch_wp = flags_q[e].ifetch_wp | if_wp;
                    flags_d[e].ifetch_bp = flags_q[e].ifetch_bp | if_bp;
                end
                if (ls_v && (ls_tag == TAG_W'(e))) begin
                    flags_d[e].mem_wp = flags_q[e].mem_wp | ls_wp;
                    flags_d[e].mem_bp = flags_q[e].mem_bp | ls_bp;
                    // Only the first breakpointing access of an instruction is kept
                    if (ls_bp && !flags_q[e].mem_bp) begin
                        addr_d[e] = ls_addr;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            addr_q  <= '0;
        end else begin
            flags_q <= flags_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        for (int s = 0; s < RET_N; s++) begin
            rd_flags[s] = flags_q[rd_tag[s]];
            rd_addr[s]  = addr_q[rd_tag[s]];
        end
    end

endmodule

// File: rtl/wpr_retire_eval.sv
module wpr_retire_eval
    import wpr_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 16,
    parameter int RET_N  = 2
) (
    input  logic [RET_N-1:0]                 ret_v,
    input  logic [RET_N-1:0][TAG_W-1:0]      ret_tag,
    input  wpr_flags_t [RET_N-1:0]           flags,
    input  logic [RET_N-1:0][ADDR_W-1:0]     addr,
    input  logic                             masked_mode,
    input  logic                             enable,
    output logic [RET_N-1:0]                 ev_iwp,
    output logic [RET_N-1:0]                 ev_lsw,
    output logic                             take,
    output wpr_when_e                        when,
    output logic [TAG_W-1:0]                 take_tag,
    output logic [ADDR_W-1:0]                take_addr
);
    logic blocked;

    // Walk slots oldest first; a taken breakpoint cancels every younger slot
    always_comb begin
        blocked   = 1'b0;
        ev_iwp    = '0;
        ev_lsw    = '0;
        take      = 1'b0;
        when      = BP_BEFORE;
        take_tag  = '0;
        take_addr = '0;
        for (int s = 0; s < RET_N; s++) begin
            if (ret_v[s] && !blocked) begin
                ev_iwp[s] = flags[s].ifetch_wp;
                ev_lsw[s] = flags[s].mem_wp;
                if (bp_allowed(masked_mode, enable) && has_bp(flags[s])) begin
                    take      = 1'b1;
                    when      = flags[s].ifetch_bp ? BP_BEFORE : BP_AFTER;
                    take_tag  = ret_tag[s];
                    take_addr = addr[s];
                    blocked   = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wpr_evt_counter.sv
module wpr_evt_counter #(
    parameter int RET_N = 2,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RET_N-1:0] inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= count + CNT_W'($countones(inc));
        end
    end

endmodule

// File: rtl/wp_retire_reporter.sv
module wp_retire_reporter
    import wpr_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 16,
    parameter int RET_N  = 2,
    parameter int CNT_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     if_hit_v,
    input  logic [TAG_W-1:0]         if_hit_tag,
    input  logic                     if_hit_wp,
    input  logic                     if_hit_bp,
    input  logic                     ls_hit_v,
    input  logic [TAG_W-1:0]         ls_hit_tag,
    input  logic                     ls_hit_wp,
    input  logic                     ls_hit_bp,
    input  logic [ADDR_W-1:0]        ls_hit_addr,
    input  logic [(1<<TAG_W)-1:0]    flush_mask,
    input  logic [RET_N-1:0]         ret_v,
    input  logic [RET_N*TAG_W-1:0]   ret_tag,
    input  logic                     bp_masked_mode,
    input  logic                     bp_enable,
    output logic [RET_N-1:0]         iwp_evt,
    output logic [RET_N-1:0]         lsw_evt,
    output logic [CNT_W-1:0]         iwp_count,
    output logic [CNT_W-1:0]         lsw_count,
    output logic                     bp_req,
    output logic                     bp_after,
    output logic [TAG_W-1:0]         bp_tag,
    output logic [ADDR_W-1:0]        bar
);
    localparam int DEPTH = 1 << TAG_W;

    logic [RET_N-1:0][TAG_W-1:0]     slot_tag;
    logic [DEPTH-1:0]                kill_mask;
    wpr_flags_t [RET_N-1:0]          slot_flags;
    logic [RET_N-1:0][ADDR_W-1:0]    slot_addr;
    logic [RET_N-1:0]                ev_iwp, ev_lsw;
    logic                            take;
    wpr_when_e                       when;
    logic [TAG_W-1:0]                take_tag;
    logic [ADDR_W-1:0]               take_addr;
    logic [WPR_NWT-1:0][RET_N-1:0]   ev_kind;
    logic [WPR_NWT-1:0][CNT_W-1:0]   cnt_all;

    for (genvar s = 0; s < RET_N; s++) begin : g_slot
        assign slot_tag[s] = ret_tag[s*TAG_W +: TAG_W];
    end

    // Retirement and flush both free the entry
    always_comb begin
        kill_mask = flush_mask;
        for (int s = 0; s < RET_N; s++) begin
            if (ret_v[s]) kill_mask[slot_tag[s]] = 1'b1;
        end
    end

    wpr_hit_table #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .RET_N(RET_N)) u_table (
        .clk       (clk),
        .rst       (rst),
        .if_v      (if_hit_v),
        .if_tag    (if_hit_tag),
        .if_wp     (if_hit_wp),
        .if_bp     (if_hit_bp),
        .ls_v      (ls_hit_v),
        .ls_tag    (ls_hit_tag),
        .ls_wp     (ls_hit_wp),
        .ls_bp     (ls_hit_bp),
        .ls_addr   (ls_hit_addr),
        .kill_mask (kill_mask),
        .rd_tag    (slot_tag),
        .rd_flags  (slot_flags),
        .rd_addr   (slot_addr)
    );

    wpr_retire_eval #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .RET_N(RET_N)) u_eval (
        .ret_v       (ret_v),
        .ret_tag     (slot_tag),
        .flags       (slot_flags),
        .addr        (slot_addr),
        .masked_mode (bp_masked_mode),
        .enable      (bp_enable),
        .ev_iwp      (ev_iwp),
        .ev_lsw      (ev_lsw),
        .take        (take),
        .when        (when),
        .take_tag    (take_tag),
        .take_addr   (take_addr)
    );

    assign ev_kind[0] = ev_iwp;
    assign ev_kind[1] = ev_lsw;

    for (genvar k = 0; k < WPR_NWT; k++) begin : g_cnt
        wpr_evt_counter #(.RET_N(RET_N), .CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (ev_kind[k]),
            .count (cnt_all[k])
        );
    end

    assign iwp_count = cnt_all[0];
    assign lsw_count = cnt_all[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            iwp_evt  <= '0;
            lsw_evt  <= '0;
            bp_req   <= 1'b0;
            bp_after <= 1'b0;
            bp_tag   <= '0;
            bar      <= '0;
        end else begin
            iwp_evt  <= ev_iwp;
            lsw_evt  <= ev_lsw;
            bp_req   <= take;
            bp_after <= take && (when == BP_AFTER);
            bp_tag   <= take ? take_tag : '0;
            if (take && (when == BP_AFTER)) begin
                bar <= take_addr;
            end
        end
    end

endmodule

// File: rtl/wp_retire_reporter_chk.sv
module wp_retire_reporter_chk #(
    parameter int ADDR_W = 16,
    parameter int RET_N  = 2,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [RET_N-1:0]  ret_v,
    input logic              bp_masked_mode,
    input logic              bp_enable,
    input logic [RET_N-1:0]  iwp_evt,
    input logic [RET_N-1:0]  lsw_evt,
    input logic [CNT_W-1:0]  iwp_count,
    input logic [CNT_W-1:0]  lsw_count,
    input logic              bp_req,
    input logic              bp_after,
    input logic [ADDR_W-1:0] bar
);
    for (genvar s = 0; s < RET_N; s++) begin : g_slot_chk
        // R3: an event on a slot needs a retirement on that slot one cycle earlier
        p_evt_at_retire_r3: assert property (@(posedge clk) disable iff (rst)
            (iwp_evt[s] || lsw_evt[s]) |-> $past(ret_v[s]));
    end

    // R2: counters step by the events shown in the same cycle
    p_iwp_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        iwp_count == $past(iwp_count) + CNT_W'($countones(iwp_evt)));

    p_lsw_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        lsw_count == $past(lsw_count) + CNT_W'($countones(lsw_evt)));

    // R6: the address register moves only with an after-execution request
    p_bar_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(bp_req && bp_after) |-> $stable(bar));

    // R6: the after flag never stands without a request
    p_after_with_req_r6: assert property (@(posedge clk) disable iff (rst)
        bp_after |-> bp_req);

    // R5: requests follow a retirement
    p_bp_needs_retire_r5: assert property (@(posedge clk) disable iff (rst)
        bp_req |-> $past(|ret_v));

    // R8: masked and disabled means no request
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (bp_masked_mode && !bp_enable) |=> !bp_req);

endmodule

bind wp_retire_reporter wp_retire_reporter_chk #(
    .ADDR_W (ADDR_W),
    .RET_N  (RET_N),
    .CNT_W  (CNT_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ret_v          (ret_v),
    .bp_masked_mode (bp_masked_mode),
    .bp_enable      (bp_enable),
    .iwp_evt        (iwp_evt),
    .lsw_evt        (lsw_evt),
    .iwp_count      (iwp_count),
    .lsw_count      (lsw_count),
    .bp_req         (bp_req),
    .bp_after       (bp_after),
    .bar            (bar)
);

// File: tb/wp_retire_reporter_bench.sv
module wp_retire_reporter_bench;
    localparam int TAG_W  = 3;
    localparam int ADDR_W = 16;
    localparam int RET_N  = 2;
    localparam int CNT_W  = 8;
    localparam int DEPTH  = 1 << TAG_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic if_hit_v = 0, if_hit_wp = 0, if_hit_bp = 0;
    logic [TAG_W-1:0] if_hit_tag = '0;
    logic ls_hit_v = 0, ls_hit_wp = 0, ls_hit_bp = 0;
    logic [TAG_W-1:0] ls_hit_tag = '0;
    logic [ADDR_W-1:0] ls_hit_addr = '0;
    logic [DEPTH-1:0] flush_mask = '0;
    logic [RET_N-1:0] ret_v = '0;
    logic [RET_N*TAG_W-1:0] ret_tag = '0;
    logic bp_masked_mode = 0, bp_enable = 0;
    logic [RET_N-1:0] iwp_evt, lsw_evt;
    logic [CNT_W-1:0] iwp_count, lsw_count;
    logic bp_req, bp_after;
    logic [TAG_W-1:0] bp_tag;
    logic [ADDR_W-1:0] bar;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of pending hits
    logic m_iw [DEPTH];
    logic m_ib [DEPTH];
    logic m_lw [DEPTH];
    logic m_lb [DEPTH];
    logic [ADDR_W-1:0] m_ad [DEPTH];
    logic [RET_N-1:0] e_iwp = '0, e_lsw = '0;
    logic e_req = 0, e_after = 0;
    logic [TAG_W-1:0] e_tag = '0;
    logic [ADDR_W-1:0] e_bar = '0;
    logic [CNT_W-1:0] e_icnt = '0, e_lcnt = '0;

    always #5 clk = ~clk;

    wp_retire_reporter #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .RET_N(RET_N), .CNT_W(CNT_W)) u_wp_retire_reporter (
        .clk(clk), .rst(rst),
        .if_hit_v(if_hit_v), .if_hit_tag(if_hit_tag), .if_hit_wp(if_hit_wp), .if_hit_bp(if_hit_bp),
        .ls_hit_v(ls_hit_v), .ls_hit_tag(ls_hit_tag), .ls_hit_wp(ls_hit_wp), .ls_hit_bp(ls_hit_bp),
        .ls_hit_addr(ls_hit_addr), .flush_mask(flush_mask), .ret_v(ret_v), .ret_tag(ret_tag),
        .bp_masked_mode(bp_masked_mode), .bp_enable(bp_enable),
        .iwp_evt(iwp_evt), .lsw_evt(lsw_evt), .iwp_count(iwp_count), .lsw_count(lsw_count),
        .bp_req(bp_req), .bp_after(bp_after), .bp_tag(bp_tag), .bar(bar)
    );

    task automatic check(input string scen, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", scen, what, act, exp);
        end
    endtask

    task automatic idle();
        if_hit_v = 0; if_hit_wp = 0; if_hit_bp = 0; if_hit_tag = '0;
        ls_hit_v = 0; ls_hit_wp = 0; ls_hit_bp = 0; ls_hit_tag = '0; ls_hit_addr = '0;
        flush_mask = '0; ret_v = '0; ret_tag = '0;
    endtask

    task automatic set_ret(input int s, input int tag);
        ret_v[s] = 1'b1;
        ret_tag[s*TAG_W +: TAG_W] = TAG_W'(tag);
    endtask

    // Compute expectations from the requirements, clock once, compare at negedge
    task automatic step(input string scen);
        logic stop;
        logic kill;
        int t;
        stop = 1'b0;
        e_iwp = '0; e_lsw = '0; e_req = 0; e_after = 0; e_tag = '0;
        for (int s = 0; s < RET_N; s++) begin
            if (ret_v[s] && !stop) begin
                t = int'(ret_tag[s*TAG_W +: TAG_W]);
                e_iwp[s] = m_iw[t];
                e_lsw[s] = m_lw[t];
                if ((!bp_masked_mode || bp_enable) && (m_ib[t] || m_lb[t])) begin
                    e_req = 1'b1;
                    e_after = !m_ib[t];
                    e_tag = TAG_W'(t);
                    if (!m_ib[t]) e_bar = m_ad[t];
                    stop = 1'b1;
                end
            end
        end
        e_icnt = e_icnt + CNT_W'($countones(e_iwp));
        e_lcnt = e_lcnt + CNT_W'($countones(e_lsw));
        for (int k = 0; k < DEPTH; k++) begin
            kill = flush_mask[k];
            for (int s = 0; s < RET_N; s++)
                if (ret_v[s] && int'(ret_tag[s*TAG_W +: TAG_W]) == k) kill = 1'b1;
            if (kill) begin
                m_iw[k] = 0; m_ib[k] = 0; m_lw[k] = 0; m_lb[k] = 0;
            end else begin
                if (if_hit_v && int'(if_hit_tag) == k) begin
                    m_iw[k] = m_iw[k] | if_hit_wp;
                    m_ib[k] = m_ib[k] | if_hit_bp;
                end
                if (ls_hit_v && int'(ls_hit_tag) == k) begin
                    if (ls_hit_bp && !m_lb[k]) m_ad[k] = ls_hit_addr;
                    m_lw[k] = m_lw[k] | ls_hit_wp;
                    m_lb[k] = m_lb[k] | ls_hit_bp;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(scen, "R3 iwp_evt", 32'(iwp_evt), 32'(e_iwp));
        check(scen, "R3 lsw_evt", 32'(lsw_evt), 32'(e_lsw));
        check(scen, "R2 iwp_count", 32'(iwp_count), 32'(e_icnt));
        check(scen, "R2 lsw_count", 32'(lsw_count), 32'(e_lcnt));
        check(scen, "R5 bp_req", 32'(bp_req), 32'(e_req));
        check(scen, "R6 bp_after", 32'(bp_after), 32'(e_after));
        check(scen, "R9 bp_tag", 32'(bp_tag), 32'(e_tag));
        check(scen, "R6 bar", 32'(bar), 32'(e_bar));
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) begin
            m_iw[k] = 0; m_ib[k] = 0; m_lw[k] = 0; m_lb[k] = 0; m_ad[k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check("R11 reset", "iwp_evt", 32'(iwp_evt), 0);
        check("R11 reset", "lsw_evt", 32'(lsw_evt), 0);
        check("R11 reset", "counts", 32'({iwp_count, lsw_count}), 0);
        check("R11 reset", "bp", 32'({bp_req, bp_after, bp_tag}), 0);
        check("R11 reset", "bar", 32'(bar), 0);

        // R1 R7 R8 R3 sweep: every tag, every hit combination, both slots, four mask settings
        for (int slot = 0; slot < RET_N; slot++) begin
            for (int tag = 0; tag < DEPTH; tag++) begin
                for (int combo = 0; combo < 16; combo++) begin
                    bp_masked_mode = tag[0];
                    bp_enable = tag[1];
                    if_hit_v = 1; if_hit_tag = TAG_W'(tag);
                    if_hit_wp = combo[0]; if_hit_bp = combo[2];
                    ls_hit_v = 1; ls_hit_tag = TAG_W'(tag);
                    ls_hit_wp = combo[1]; ls_hit_bp = combo[3];
                    ls_hit_addr = ADDR_W'(tag * 16'h0111 + combo + slot * 16'h1000);
                    step("R1 first hits");
                    if_hit_v = 1; if_hit_tag = TAG_W'(tag);
                    if_hit_wp = combo[0]; if_hit_bp = combo[2];
                    ls_hit_v = 1; ls_hit_tag = TAG_W'(tag);
                    ls_hit_wp = combo[1]; ls_hit_bp = combo[3];
                    ls_hit_addr = ADDR_W'(16'hBEEF - combo);
                    step("R7 repeated hits");
                    if (slot == 1) set_ret(0, (tag + 1) % DEPTH);
                    set_ret(slot, tag);
                    step("R8 R1 retire");
                end
            end
        end
        bp_masked_mode = 0; bp_enable = 0;

        // R9: older data breakpoint and younger instruction breakpoint in one clock
        ls_hit_v = 1; ls_hit_tag = 3'd2; ls_hit_bp = 1; ls_hit_addr = 16'h4A4A;
        if_hit_v = 1; if_hit_tag = 3'd5; if_hit_bp = 1; if_hit_wp = 1;
        step("R9 load");
        ls_hit_v = 1; ls_hit_tag = 3'd5; ls_hit_wp = 1;
        step("R9 load2");
        set_ret(0, 2); set_ret(1, 5);
        step("R9 dual retire");
        check("R9 dual retire", "bp_after", 32'(bp_after), 1);
        set_ret(0, 5);
        step("R9 younger cleared");

        // R4: flush clears; hit in flush cycle dropped; hit in retire cycle dropped
        if_hit_v = 1; if_hit_tag = 3'd4; if_hit_wp = 1;
        step("R4 hit");
        flush_mask = 8'h10;
        step("R4 flush");
        set_ret(0, 4);
        step("R4 retire flushed");
        ls_hit_v = 1; ls_hit_tag = 3'd6; ls_hit_wp = 1; ls_hit_bp = 1; ls_hit_addr = 16'h0606;
        flush_mask = 8'h40;
        step("R4 hit with flush");
        set_ret(1, 6);
        step("R4 retire after flush-hit");
        ls_hit_v = 1; ls_hit_tag = 3'd7; ls_hit_wp = 1;
        set_ret(0, 7);
        step("R4 hit with retire");
        set_ret(0, 7);
        step("R4 retire again");

        // R10 and R5: both breakpoint kinds on one instruction
        if_hit_v = 1; if_hit_tag = 3'd1; if_hit_bp = 1;
        ls_hit_v = 1; ls_hit_tag = 3'd1; ls_hit_bp = 1; ls_hit_addr = 16'h7777;
        step("R10 load");
        set_ret(0, 1);
        step("R10 R5 retire");
        check("R10 before", "bp_after", 32'(bp_after), 0);

        // R12: retire with nothing pending
        set_ret(0, 0); set_ret(1, 3);
        step("R12 empty retire");

        // R2 pseudo-random mix of hits, flushes, retirements and mask settings
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            int t0;
            r = $urandom;
            bp_masked_mode = r[0]; bp_enable = r[1];
            if_hit_v = r[2]; if_hit_tag = r[5:3]; if_hit_wp = r[6]; if_hit_bp = r[7] & r[8];
            ls_hit_v = r[9]; ls_hit_tag = r[12:10]; ls_hit_wp = r[13]; ls_hit_bp = r[14];
            ls_hit_addr = r[31:16];
            if (r[15] && r[8] && r[2]) flush_mask = DEPTH'(1) << r[20:18];
            t0 = int'(r[27:25]);
            if (r[28]) set_ret(0, t0);
            if (r[29]) set_ret(1, (t0 + 1 + int'(r[31:30])) % DEPTH);
            step("R2 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule